// File: doc/BRIEF.md
# Segment-Interleaved LED Scan Driver

This block lights a row of seven-segment displays through an external chain of serial-in shift registers with latched outputs. Each display has its own pattern register, and the block scans by segment position rather than by digit. On every accepted refresh tick it takes one segment position and collects that segment's bit from every display. It sends those bits out on a serial data/clock pair, pulses a storage strobe so the chain's outputs change together, and then enables the matching one-hot segment-select line. The column of bits is read from the pattern registers at the start of each step, so no interleaved copy of the patterns is kept.

The sequencer is a four-state machine:
- **IDLE**: waits with the current segment lit.
- **LOW**: the serial clock is low and the data line already holds the bit.
- **HIGH**: the serial clock is high.
- **LATCH**: one strobe cycle.

The transitions are:
- *accept*: IDLE to LOW on a tick.
- *rise*: LOW to HIGH when the low phase ends.
- *next-bit*: HIGH to LOW when the high phase ends and more displays remain.
- *last-bit*: HIGH to LATCH after the final display's bit.
- *enable*: LATCH to IDLE. It loads the segment select and advances the position.

The serial clock period is `CLK_DIV` system cycles, where `CLK_DIV` must be at least 2. The high phase lasts `CLK_DIV/2` cycles and the low phase lasts the remainder.

Top module: `ledscan_top`

## Requirements
- R1: Synchronous active-high reset clears every pattern register, sets the next segment position to 1, drives `ser_clk`, `ser_data`, `ser_strobe`, `seg_sel` and `overrun` to zero, and leaves the state machine in IDLE.
- R2: A step for segment position s (1..7) sends exactly `NUM_DISP` bits. The k-th bit sent (k = 1..`NUM_DISP`) equals bit s-1 of the pattern of the display at write address k-1.
- R3: Every bit is placed on `ser_data` while `ser_clk` is low. `ser_clk` is low for `CLK_DIV - CLK_DIV/2` cycles before each rise and high for `CLK_DIV/2` cycles. `ser_data` stays stable while `ser_clk` is high.
- R4: After the high phase of the last bit, `ser_strobe` is high for exactly one cycle with `ser_clk` low. A step lasts `NUM_DISP*CLK_DIV + 1` cycles from acceptance to the end of the strobe.
- R5: `seg_sel` is all zero from the cycle after an accepted tick through the strobe cycle. In the cycle after the strobe it becomes one-hot, with bit s-1 set for position s, and it holds until the next accepted tick.
- R6: Successive steps visit positions 1, 2, ... 7 and then wrap to 1.
- R7: A tick that arrives outside IDLE is ignored: the step in progress keeps its bit count and length. The tick also sets `overrun`, which stays set until reset.
- R8: A write with `wr_en` high stores `wr_data` into the display at `wr_addr`, with bit 7 forced to 0. Addresses at or above `NUM_DISP` are ignored. A write made during a step leaves that step's bits unchanged and shows from the next step on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Pattern write strobe |
| wr_addr | input | $clog2(NUM_DISP) | Display index to write, 0-based |
| wr_data | input | PAT_W | Pattern, bit i drives segment i+1 |
| tick | input | 1 | Refresh tick, starts one segment step |
| ser_data | output | 1 | Serial data to the register chain |
| ser_clk | output | 1 | Serial shift clock |
| ser_strobe | output | 1 | Storage strobe for the chain |
| seg_sel | output | NUM_SEG | One-hot segment enable |
| overrun | output | 1 | Sticky flag: tick arrived during a step |

## Verification
The bench builds the block with `NUM_DISP = 5` and `CLK_DIV = 3`. The odd divider gives unequal phases of two low cycles and one high cycle. The 3-bit address then reaches out-of-range values 5 to 7. With these small values, every bit of every segment position can be compared for several pattern sets: all zero, mixed values, a walking segment and all ones. Each full scan also covers the wrap from position 7 to position 1. Mid-step writes, mid-step ticks and ignored addresses are each placed inside a step and checked on the following steps.

// File: rtl/ledscan_pkg.sv
package ledscan_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LOW   = 2'd1,
        ST_HIGH  = 2'd2,
        ST_LATCH = 2'd3
    } scan_state_t;
endpackage

// File: rtl/ledscan_patbank.sv
// Per-display pattern storage with a column read for one segment position.
module ledscan_patbank #(
    parameter int NUM_DISP = 24,
    parameter int NUM_SEG  = 7,
    parameter int PAT_W    = 8,
    localparam int AW      = $clog2(NUM_DISP),
    localparam int SW      = $clog2(NUM_SEG)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [AW-1:0]       wr_addr,
    input  logic [PAT_W-1:0]    wr_data,
    input  logic [SW-1:0]       seg_idx,
    output logic [NUM_DISP-1:0] column
);
    localparam logic [PAT_W-1:0] SEG_MASK = PAT_W'((1 << NUM_SEG) - 1);

    for (genvar d = 0; d < NUM_DISP; d++) begin : g_disp
        logic [PAT_W-1:0] pat_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                pat_q <= '0;
            end else if (wr_en && (wr_addr == AW'(d))) begin
                pat_q <= wr_data & SEG_MASK;
            end
        end

        // bit for this display at the requested segment position
        assign column[d] = pat_q[seg_idx];

        // R8: the unused top bit never holds a one
        p_top_bit_clear_r8: assert property (@(posedge clk) disable iff (rst)
            pat_q[PAT_W-1] == 1'b0);
    end
endmodule

// File: rtl/ledscan_phase.sv
// Serial clock phase timer: LO cycles low, HI cycles high.
module ledscan_phase #(
    parameter int CLK_DIV = 4,
    localparam int HI     = CLK_DIV / 2,
    localparam int LO     = CLK_DIV - HI,
    localparam int CW     = $clog2(LO + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic high,
    output logic last
);
    logic [CW-1:0] cnt_q;

    always_comb begin
        if (high) last = run && (cnt_q == CW'(HI - 1));
        else      last = run && (cnt_q == CW'(LO - 1));
    end

    always_ff @(posedge clk) begin
        if (rst || !run || last) cnt_q <= '0;
        else                     cnt_q <= cnt_q + 1'b1;
    end

    // R3: the counter never runs beyond the longer phase
    p_phase_bound_r3: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CW'(LO - 1));
endmodule

// File: rtl/ledscan_seq.sv
// Segment-step sequencer: shifts one column, strobes, enables the segment.
module ledscan_seq #(
    parameter int NUM_DISP = 24,
    parameter int NUM_SEG  = 7,
    localparam int BW      = $clog2(NUM_DISP),
    localparam int SW      = $clog2(NUM_SEG)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                tick,
    input  logic [NUM_DISP-1:0] column,
    input  logic                phase_last,
    output logic [SW-1:0]       seg_idx,
    output logic                phase_run,
    output logic                phase_high,
    output logic                ser_data,
    output logic                ser_clk,
    output logic                ser_strobe,
    output logic [NUM_SEG-1:0]  seg_sel,
    output logic                overrun
);
    import ledscan_pkg::*;

    scan_state_t          state_q, state_d;
    logic [NUM_DISP-1:0]  col_q;
    logic [BW-1:0]        bit_q;
    logic [SW-1:0]        seg_q;
    logic [NUM_SEG-1:0]   sel_q;
    logic                 ovr_q;
    logic                 last_bit;

    assign last_bit = (bit_q == BW'(NUM_DISP - 1));

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (tick)       state_d = ST_LOW;
            ST_LOW:   if (phase_last) state_d = ST_HIGH;
            ST_HIGH:  if (phase_last) state_d = last_bit ? ST_LATCH : ST_LOW;
            ST_LATCH:                 state_d = ST_IDLE;
            default:                  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (rst) begin
            col_q <= '0;
            bit_q <= '0;
            seg_q <= '0;
            sel_q <= '0;
            ovr_q <= 1'b0;
        end else begin
            if (tick && (state_q != ST_IDLE)) ovr_q <= 1'b1;
            unique case (state_q)
                ST_IDLE: begin
                    if (tick) begin
                        col_q <= column;
                        bit_q <= '0;
                        sel_q <= '0;
                    end
                end
                ST_HIGH: begin
                    if (phase_last) begin
                        col_q <= col_q >> 1;
                        if (!last_bit) bit_q <= bit_q + 1'b1;
                    end
                end
                ST_LATCH: begin
                    sel_q <= NUM_SEG'(1) << seg_q;
                    seg_q <= (seg_q == SW'(NUM_SEG - 1)) ? '0 : seg_q + 1'b1;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        phase_run  = (state_q == ST_LOW) || (state_q == ST_HIGH);
        phase_high = (state_q == ST_HIGH);
        ser_clk    = (state_q == ST_HIGH);
        ser_strobe = (state_q == ST_LATCH);
        ser_data   = phase_run & col_q[0];
        seg_sel    = sel_q;
        overrun    = ovr_q;
        seg_idx    = seg_q;
    end

    p_sel_onehot_r5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(seg_sel));
    p_dark_while_shift_r5: assert property (@(posedge clk) disable iff (rst)
        (ser_clk || ser_strobe) |-> (seg_sel == '0));
    p_lit_after_latch_r5: assert property (@(posedge clk) disable iff (rst)
        ser_strobe |=> $onehot(seg_sel));
    p_strobe_single_r4: assert property (@(posedge clk) disable iff (rst)
        ser_strobe |=> !ser_strobe);
    p_strobe_clk_low_r4: assert property (@(posedge clk) disable iff (rst)
        ser_strobe |-> !ser_clk);
    p_data_hold_r3: assert property (@(posedge clk) disable iff (rst)
        ser_clk |-> $stable(ser_data));
    p_overrun_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        overrun |=> overrun);
endmodule

// File: rtl/ledscan_top.sv
module ledscan_top #(
    parameter int NUM_DISP = 24,
    parameter int NUM_SEG  = 7,
    parameter int PAT_W    = 8,
    parameter int CLK_DIV  = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_en,
    input  logic [$clog2(NUM_DISP)-1:0] wr_addr,
    input  logic [PAT_W-1:0]            wr_data,
    input  logic                        tick,
    output logic                        ser_data,
    output logic                        ser_clk,
    output logic                        ser_strobe,
    output logic [NUM_SEG-1:0]          seg_sel,
    output logic                        overrun
);
    localparam int SW = $clog2(NUM_SEG);

    logic [NUM_DISP-1:0] column;
    logic [SW-1:0]       seg_idx;
    logic                phase_run, phase_high, phase_last;

    ledscan_patbank #(
        .NUM_DISP(NUM_DISP), .NUM_SEG(NUM_SEG), .PAT_W(PAT_W)
    ) u_bank (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .seg_idx(seg_idx), .column(column)
    );

    ledscan_phase #(.CLK_DIV(CLK_DIV)) u_phase (
        .clk(clk), .rst(rst), .run(phase_run), .high(phase_high),
        .last(phase_last)
    );

    ledscan_seq #(.NUM_DISP(NUM_DISP), .NUM_SEG(NUM_SEG)) u_seq (
        .clk(clk), .rst(rst), .tick(tick), .column(column),
        .phase_last(phase_last), .seg_idx(seg_idx),
        .phase_run(phase_run), .phase_high(phase_high),
        .ser_data(ser_data), .ser_clk(ser_clk), .ser_strobe(ser_strobe),
        .seg_sel(seg_sel), .overrun(overrun)
    );
endmodule

// File: tb/ledscan_top_tb.sv
module ledscan_top_tb;
    localparam int ND = 5;
    localparam int NS = 7;
    localparam int N  = 3;
    localparam int HI = N / 2;
    localparam int LO = N - HI;
    localparam int AW = $clog2(ND);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic tick = 1'b0;
    logic ser_data, ser_clk, ser_strobe, overrun;
    logic [NS-1:0] seg_sel;

    int checks = 0;
    int fails  = 0;
    logic [7:0] mdl [ND];
    int seg_pos = 0;

    always #2 clk = ~clk;

    ledscan_top #(.NUM_DISP(ND), .NUM_SEG(NS), .PAT_W(8), .CLK_DIV(N)) u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .tick(tick), .ser_data(ser_data),
        .ser_clk(ser_clk), .ser_strobe(ser_strobe), .seg_sel(seg_sel),
        .overrun(overrun)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write_pat(input int a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (a < ND) mdl[a] = d & 8'h7f;
    endtask

    // one segment step; optional write or extra tick inside it
    task automatic step(input bit do_wr, input int wa, input logic [7:0] wd,
                        input bit extra_tick);
        int cyc = 0, nbits = 0, lowrun = 0, highrun = 0;
        bit prevclk = 0, done = 0;
        logic prevdata = 1'b0;
        logic [ND-1:0] got = '0;
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
        while (!done && cyc < 200) begin
            if (ser_strobe) begin
                done = 1;
                chk(ser_clk == 1'b0, "R4 strobe with clk low", ser_clk, 0);
                chk(highrun == HI, "R3 last high phase", highrun, HI);
            end else if (ser_clk) begin
                if (!prevclk) begin
                    if (nbits < ND) got[nbits] = ser_data;
                    nbits++;
                    chk(lowrun == LO, "R3 low phase length", lowrun, LO);
                end else begin
                    chk(ser_data == prevdata, "R3 data stable while high", ser_data, prevdata);
                end
                highrun++; lowrun = 0;
            end else begin
                if (prevclk) chk(highrun == HI, "R3 high phase length", highrun, HI);
                highrun = 0; lowrun++;
            end
            if (seg_sel != '0) chk(0, "R5 dark while shifting", seg_sel, 0);
            prevclk = ser_clk; prevdata = ser_data;
            cyc++;
            if (cyc == 3) begin
                if (do_wr) begin wr_en = 1'b1; wr_addr = AW'(wa); wr_data = wd; end
                if (extra_tick) tick = 1'b1;
            end else if (cyc == 4) begin
                wr_en = 1'b0; tick = 1'b0;
            end
            if (!done) @(negedge clk);
        end
        chk(done, "R4 strobe seen", done, 1);
        chk(cyc == ND * N + 1, "R4/R7 step length", cyc, ND * N + 1);
        chk(nbits == ND, "R2 bit count", nbits, ND);
        for (int k = 0; k < ND; k++)
            chk(got[k] == mdl[k][seg_pos], "R2 bit value", got[k], mdl[k][seg_pos]);
        @(negedge clk);
        chk(seg_sel == NS'(1 << seg_pos), "R5/R6 segment enabled", seg_sel, 1 << seg_pos);
        if (do_wr && wa < ND) mdl[wa] = wd & 8'h7f;
        seg_pos = (seg_pos + 1) % NS;
    endtask

    task automatic full_scan();
        for (int s = 0; s < NS; s++) step(0, 0, 8'h00, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        for (int d = 0; d < ND; d++) mdl[d] = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(ser_clk == 0, "R1 ser_clk", ser_clk, 0);
        chk(ser_data == 0, "R1 ser_data", ser_data, 0);
        chk(ser_strobe == 0, "R1 ser_strobe", ser_strobe, 0);
        chk(seg_sel == 0, "R1 seg_sel", seg_sel, 0);
        chk(overrun == 0, "R1 overrun", overrun, 0);
        // R1 cleared patterns, first position 1; R6 wrap
        full_scan();
        step(0, 0, 8'h00, 0);
        // R5 hold in idle
        repeat (6) @(negedge clk);
        chk(seg_sel == NS'(1 << ((seg_pos + NS - 1) % NS)), "R5 hold in idle",
            seg_sel, 1 << ((seg_pos + NS - 1) % NS));
        // mixed patterns, bit 7 set in writes (R8)
        for (int d = 0; d < ND; d++) write_pat(d, 8'h80 | 8'((d * 37 + 19) & 8'h7f));
        full_scan();
        // walking segment
        for (int d = 0; d < ND; d++) write_pat(d, 8'(1 << (d % NS)));
        full_scan();
        // all ones
        for (int d = 0; d < ND; d++) write_pat(d, 8'hff);
        full_scan();
        // R8 out-of-range addresses ignored
        for (int d = 0; d < ND; d++) write_pat(d, 8'h00);
        for (int a = ND; a < (1 << AW); a++) write_pat(a, 8'h7f);
        full_scan();
        // R8 mid-step writes apply from the next step
        for (int s = 0; s < NS; s++) step(1, s % ND, 8'((s * 53 + 7) & 8'hff), 0);
        full_scan();
        // R7 tick during a step ignored, overrun set and sticky
        chk(overrun == 0, "R7 no overrun yet", overrun, 0);
        step(0, 0, 8'h00, 1);
        chk(overrun == 1, "R7 overrun set", overrun, 1);
        full_scan();
        chk(overrun == 1, "R7 overrun sticky", overrun, 1);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule